// File: doc/BRIEF.md
# Chip-Select Gated Serial Readout Port

This block sends a finished 16-bit conversion result to an external host over a three-wire serial link. The host pulls an active-low select line low and supplies its own shift clock. The block answers on a data line that it drives only while a word, or the bit it is finishing, is on the wire. The conversion sequencer feeds the block a parallel result word and a level data-ready flag. The block returns a one-cycle completion pulse once all sixteen bits have left, and the sequencer uses that pulse to clear data-ready.

The select and shift-clock inputs are asynchronous to the master clock. Each one passes through a two-flop synchronizer, and its edges are detected in the master-clock domain. A selection counts only while data-ready is high. The word is captured at the moment of selection, so a result that the sequencer produces during a readout does not reach the wire until the current word has completed or been abandoned. After selection, the first shift-clock edge that counts must be a rising one. Only after that do falling edges advance the data.

Top module: `sdout_port`

## Requirements
- R1: The word is sent MSB first. Bit 15 drives `sdata` with `sdata_oe` high from the cycle in which the selection is recognised.
- R2: Once the port is armed, each recognised falling edge of `sclk` moves `sdata` to the next lower bit. Between falling edges `sdata` holds its value.
- R3: After a selection, falling edges of `sclk` are ignored until a rising edge of `sclk` has been seen. A rising edge that happens before the selection does not arm the port.
- R4: `cs_n` low while `res_valid` is low does not start a readout. If `res_valid` then rises while `cs_n` is still low, the selection is recognised.
- R5: The sixteenth recognised falling edge gives a `word_done` pulse exactly one cycle long, and `sdata_oe` drops in that same cycle. No new readout starts until `cs_n` has returned high.
- R6: If `cs_n` goes high after the port is armed and before the word completes, the current bit stays driven until the next falling edge of `sclk`. The output then floats and no `word_done` is given.
- R7: If `cs_n` goes high before the arming rising edge, the output floats at once and no `word_done` is given.
- R8: The word on `res_word` is captured when the selection is recognised. Later changes on `res_word` do not affect the bits being sent.
- R9: During and right after reset, `sdata_oe` and `word_done` are low.
- R10: A change on `cs_n` or `sclk` that is made between clock edges takes effect at the outputs after the third rising master-clock edge that follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Asynchronous active-low select from host |
| sclk | input | 1 | Asynchronous host shift clock |
| res_word | input | 16 | Conversion result from the sequencer |
| res_valid | input | 1 | Data-ready level from the sequencer |
| sdata | output | 1 | Serial data value (0 when not enabled) |
| sdata_oe | output | 1 | Enable for the tri-state data pad driver |
| word_done | output | 1 | One-cycle pulse after the last bit |

## Verification
The embedded properties check these rules on every cycle: enable rises only when a selection is valid against data-ready, the data line holds still between falling edges, nothing shifts before arming, and the completion pulse lasts one cycle, follows a falling edge and coincides with the output floating. The bench's scenarios are needed for the rest: MSB-first order across a whole word, the drain after an early release, holding off a new word after completion, and the three-edge synchronizer latency. For these it compares the outputs against a behavioural reference model on every clock.

// File: rtl/sdo_pkg.sv
package sdo_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,   // floating, waiting for a valid selection
    ST_ARM,    // first bit driven, waiting for a rising sclk
    ST_SHIFT,  // falling sclk edges advance the word
    ST_DRAIN,  // released early, finishing the current bit
    ST_HOLD    // word complete, waiting for deselect
  } sdo_state_e;

  // True when the count of bits already sent marks the final bit.
  function automatic logic is_last_bit(input int unsigned sent, input int unsigned width);
    return sent == width - 1;
  endfunction
endpackage

// File: rtl/sdo_sync2.sv
module sdo_sync2 #(
  parameter int unsigned N = 1,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] async_in,
  output logic [N-1:0] sync_out
);
  logic [N-1:0] meta_q;
  logic [N-1:0] sync_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= async_in;
      sync_q <= meta_q;
    end
  end

  assign sync_out = sync_q;
endmodule

// File: rtl/sdo_edge.sv
module sdo_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  output logic rise,
  output logic fall
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= level;
  end

  assign rise = level & ~prev_q;
  assign fall = ~level & prev_q;
endmodule

// File: rtl/sdo_engine.sv
module sdo_engine
  import sdo_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cs_s,
  input  logic         sclk_rise,
  input  logic         sclk_fall,
  input  logic [W-1:0] res_word,
  input  logic         res_valid,
  output logic         sdata,
  output logic         sdata_oe,
  output logic         word_done
);
  localparam int unsigned CW = (W > 1) ? $clog2(W) : 1;

  sdo_state_e   st_q;
  logic [W-1:0] sh_q;
  logic [CW-1:0] sent_q;
  logic         done_q;

  // Named events for the properties below.
  logic select_ev;
  logic last_ev;
  logic shift_ev;
  assign select_ev = (st_q == ST_IDLE) && !cs_s && res_valid;
  assign last_ev   = (st_q == ST_SHIFT) && sclk_fall && is_last_bit(int'(sent_q), W);
  assign shift_ev  = (st_q == ST_SHIFT) && sclk_fall && !last_ev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      sh_q   <= '0;
      sent_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (select_ev) begin
          sh_q   <= res_word;
          sent_q <= '0;
          st_q   <= ST_ARM;
        end
        ST_ARM: begin
          if (cs_s)           st_q <= ST_IDLE;
          else if (sclk_rise) st_q <= ST_SHIFT;
        end
        ST_SHIFT: begin
          if (last_ev) begin
            done_q <= 1'b1;
            st_q   <= cs_s ? ST_IDLE : ST_HOLD;
          end else if (shift_ev) begin
            sh_q   <= {sh_q[W-2:0], 1'b0};
            sent_q <= sent_q + 1'b1;
            if (cs_s) st_q <= ST_IDLE;
          end else if (cs_s) begin
            st_q <= ST_DRAIN;
          end
        end
        ST_DRAIN: if (sclk_fall) st_q <= ST_IDLE;
        ST_HOLD:  if (cs_s)      st_q <= ST_IDLE;
        default:  st_q <= ST_IDLE;
      endcase
    end
  end

  assign sdata_oe  = (st_q == ST_ARM) || (st_q == ST_SHIFT) || (st_q == ST_DRAIN);
  assign sdata     = sdata_oe & sh_q[W-1];
  assign word_done = done_q;

  assert_select_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdata_oe) |-> $past(!cs_s && res_valid));
  assert_bit_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sdata_oe && $past(sdata_oe) && !$past(sclk_fall)) |-> $stable(sdata));
  assert_no_shift_unarmed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_ARM) && sclk_fall) |=> $stable(sh_q));
  assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |=> !word_done);
  assert_done_floats_R5: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |-> (!sdata_oe && $past(sclk_fall)));
endmodule

// File: rtl/sdout_port.sv
module sdout_port #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cs_n,
  input  logic         sclk,
  input  logic [W-1:0] res_word,
  input  logic         res_valid,
  output logic         sdata,
  output logic         sdata_oe,
  output logic         word_done
);
  logic [1:0] pins_s;
  logic       cs_s;
  logic       sclk_s;
  logic       sclk_rise;
  logic       sclk_fall;

  // bit 1: select (idles high), bit 0: shift clock
  sdo_sync2 #(.N(2), .RST_VAL(2'b10)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in ({cs_n, sclk}),
    .sync_out (pins_s)
  );
  assign cs_s   = pins_s[1];
  assign sclk_s = pins_s[0];

  sdo_edge u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .level (sclk_s),
    .rise  (sclk_rise),
    .fall  (sclk_fall)
  );

  sdo_engine #(.W(W)) u_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_s      (cs_s),
    .sclk_rise (sclk_rise),
    .sclk_fall (sclk_fall),
    .res_word  (res_word),
    .res_valid (res_valid),
    .sdata     (sdata),
    .sdata_oe  (sdata_oe),
    .word_done (word_done)
  );

  assert_reset_quiet_R9: assert property (@(posedge clk)
    !rst_n |=> (!sdata_oe && !word_done));
endmodule

// File: tb/tb_sdout_port.sv
module tb_sdout_port;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1;
  logic sclk = 1'b0;
  logic [15:0] res_word = '0;
  logic res_valid = 1'b0;
  logic sdata, sdata_oe, word_done;

  int checks = 0;
  int errors = 0;
  int done_cnt = 0;
  string cur_req = "R9";
  bit finished = 0;

  always #5 clk = ~clk;

  sdout_port dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk),
    .res_word(res_word), .res_valid(res_valid),
    .sdata(sdata), .sdata_oe(sdata_oe), .word_done(word_done)
  );

  // Behavioural reference: pin samples delayed in small arrays, word index as integer.
  int m_mode;         // 0 float,1 wait-rise,2 shifting,3 draining,4 wait-deselect
  int m_idx;
  logic [15:0] m_word;
  bit m_done;
  bit cs_d[2];
  bit sc_d[3];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_idx = 15; m_word = '0; m_done = 0;
      cs_d[0] = 1; cs_d[1] = 1; sc_d[0] = 0; sc_d[1] = 0; sc_d[2] = 0;
    end else begin
      bit c, r, f;
      c = cs_d[1];
      r = sc_d[1] && !sc_d[2];
      f = !sc_d[1] && sc_d[2];
      m_done = 0;
      case (m_mode)
        0: if (!c && res_valid) begin m_word = res_word; m_idx = 15; m_mode = 1; end
        1: if (c) m_mode = 0; else if (r) m_mode = 2;
        2: if (f) begin
             if (m_idx == 0) begin m_done = 1; m_mode = c ? 0 : 4; end
             else begin m_idx--; if (c) m_mode = 0; end
           end else if (c) m_mode = 3;
        3: if (f) m_mode = 0;
        4: if (c) m_mode = 0;
        default: m_mode = 0;
      endcase
      sc_d[2] = sc_d[1]; sc_d[1] = sc_d[0]; sc_d[0] = sclk;
      cs_d[1] = cs_d[0]; cs_d[0] = cs_n;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // Compare against the model on every cycle, away from the active edge.
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      bit e_oe;
      e_oe = (m_mode >= 1 && m_mode <= 3);
      chk(sdata_oe == e_oe, {cur_req, " oe"}, sdata_oe, e_oe);
      chk(word_done == m_done, {cur_req, " done"}, word_done, m_done);
      if (e_oe) chk(sdata == m_word[m_idx], {cur_req, " bit"}, sdata, m_word[m_idx]);
      if (word_done) done_cnt++;
    end
  end

  task automatic wn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      sclk = 1'b1; wn(4);
      sclk = 1'b0; wn(4);
    end
  endtask

  initial begin
    wn(4);
    chk(sdata_oe == 0 && word_done == 0, "R9 reset", {sdata_oe, word_done}, 0);
    rst_n = 1'b1;
    wn(3);
    chk(sdata_oe == 0, "R9 after reset", sdata_oe, 0);

    // R1 R2 R5 R10: full readout
    cur_req = "R1/R2";
    res_word = 16'hA5C3; res_valid = 1'b1;
    wn(1);
    cs_n = 1'b0;
    @(posedge clk); @(posedge clk); #1;
    chk(sdata_oe == 0, "R10 two edges", sdata_oe, 0);
    @(posedge clk); #1;
    chk(sdata_oe == 1, "R10 third edge", sdata_oe, 1);
    chk(sdata == 1'b1, "R1 msb first", sdata, 1);
    wn(2);
    done_cnt = 0;
    pulses(16);
    chk(done_cnt == 1, "R5 one done", done_cnt, 1);
    chk(sdata_oe == 0, "R5 float after word", sdata_oe, 0);

    // R5: new data while still selected must not restart
    cur_req = "R5";
    res_word = 16'h1234; res_valid = 1'b1;
    wn(10);
    chk(sdata_oe == 0, "R5 no restart while selected", sdata_oe, 0);
    cs_n = 1'b1; wn(6);
    cs_n = 1'b0; wn(6);
    chk(sdata_oe == 1 && sdata == 1'b0, "R5 restart after deselect", sdata_oe, 1);
    pulses(16);
    res_valid = 1'b0; cs_n = 1'b1; wn(6);

    // R4: select while data-ready is low
    cur_req = "R4";
    res_word = 16'h8001;
    cs_n = 1'b0; wn(10);
    chk(sdata_oe == 0, "R4 ignored without ready", sdata_oe, 0);
    res_valid = 1'b1; wn(3);
    chk(sdata_oe == 1 && sdata == 1'b1, "R4 recognised on ready", sdata_oe, 1);

    // R7: release before arming
    cur_req = "R7";
    done_cnt = 0;
    cs_n = 1'b1; wn(4);
    chk(sdata_oe == 0 && done_cnt == 0, "R7 float at once", sdata_oe, 0);

    // R3: clock already high at selection; first fall ignored
    cur_req = "R3";
    res_word = 16'hC00F;
    sclk = 1'b1; wn(6);
    cs_n = 1'b0; wn(6);
    sclk = 1'b0; wn(6);
    chk(sdata == 1'b1 && sdata_oe == 1, "R3 fall before rise ignored", sdata, 1);
    sclk = 1'b1; wn(4); sclk = 1'b0; wn(4);
    chk(sdata == 1'b1, "R3 second bit after arm", sdata, 1);
    sclk = 1'b1; wn(4); sclk = 1'b0; wn(4);
    chk(sdata == 1'b0, "R3 third bit", sdata, 0);

    // R6: release mid-word while sclk high
    cur_req = "R6";
    done_cnt = 0;
    sclk = 1'b1; wn(3);
    cs_n = 1'b1; wn(8);
    chk(sdata_oe == 1, "R6 bit still driven", sdata_oe, 1);
    sclk = 1'b0; wn(6);
    chk(sdata_oe == 0 && done_cnt == 0, "R6 floats without done", sdata_oe, 0);

    // R8: word changes during readout
    cur_req = "R8";
    res_word = 16'h0F0F; wn(2);
    cs_n = 1'b0; wn(6);
    res_word = 16'hFFFF;
    pulses(4);
    chk(sdata == 1'b1 && sdata_oe == 1, "R8 captured word bit 11", sdata, 1);
    res_word = 16'h0000;
    pulses(12);
    chk(done_cnt == 1, "R8 done", done_cnt, 1);
    res_valid = 1'b0; cs_n = 1'b1; wn(6);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule